// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds three alarm bytes (minutes, hours and day of week, in the same BCD layout as the running time fields). It compares them against the current time once per check window. The top bit of each byte is a mask bit. The masks widen the alarm step by step: day masked gives a daily alarm, day and hours masked gives an hourly alarm, and all three masked gives an alarm every minute on the seconds rollover. A hit sets a sticky flag. An interrupt request follows the flag unless the interrupt mask input is high.

Software reaches the bytes through a small register port, with select codes 0 = minutes byte, 1 = hours byte, 2 = day byte and 3 = unused. Any read or write of a valid alarm byte clears the flag, so servicing the alarm also acknowledges it. The check window strobe comes from the timekeeping logic while the hundredths count is 99. The seconds-wrap strobe marks the second that rolls over to a new minute.

Top module: `tod_alarm_match`

## Requirements
- R1: A write with select 0 or 1 stores all 8 bits of wr_data. The byte then appears on rd_data one cycle later while that select is applied. Select 3 always reads 0x00.
- R2: A write with select 2 stores bits 7 and 2:0 only. Bits 6:3 of the day byte always read 0.
- R3: With no mask bits set, a check window sets the flag only when minutes bits 6:0, hours bits 6:0 and day bits 2:0 all equal the stored bytes.
- R4: With only the day mask (bit 7 of the day byte) set, a check window sets the flag when minutes and hours match, for any day.
- R5: With the day and hours masks set and the minutes mask clear, a check window sets the flag when minutes match.
- R6: With all three mask bits set, a check window sets the flag only when seq_wrap is high. The time fields are ignored.
- R7: A minutes or hours mask bit has no effect unless the masks of every larger unit are also set. For example, the minutes mask alone still requires a full match.
- R8: Once a match has set the flag, later check windows that still match do not set it again. A new set needs a check window without a match first.
- R9: A read or write with select 0, 1 or 2 clears the flag on the next cycle. An access with select 3 leaves the flag unchanged.
- R10: When a flag-setting check and a clearing access happen in the same cycle, the flag ends up set.
- R11: irq_out equals the flag while irq_mask is low and is 0 while irq_mask is high. irq_mask never changes the flag.
- R12: After reset the flag, irq_out and all three alarm bytes are 0.
- R13: The flag rises in the cycle after the check window that hits. Without a check window it never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Alarm byte select: 0 minutes, 1 hours, 2 day, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (counts as an access for clearing) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected alarm byte |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD with format bits |
| now_day | input | 8 | Current day of week |
| seq_wrap | input | 1 | Seconds roll from 59 to 00 at this check |
| chk_win | input | 1 | Check window strobe (hundredths at 99) |
| irq_mask | input | 1 | Suppresses the interrupt request |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_out | output | 1 | Mask-gated interrupt request |

## Verification
On every cycle, the assertions check how the flag moves: it sets after a fresh hit, clears after a valid access unless a set happens in the same cycle, and holds otherwise. They also check that the reserved day bits stay zero, that writes are stored, and that the interrupt stays low while masked. Only the bench scenarios show the mask hierarchy choosing the right fields, the minute-rollover mode, and the rule that a hit fires once per matching instant. The bench compares the design against a model built from the requirements, both in directed cases and under random traffic.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    parameter int BYTE_W   = 8;
    parameter int MASK_POS = 7;
    parameter int FIELD_W  = 7;
    parameter int DAY_W    = 3;
    parameter int SEL_W    = 2;

    localparam logic [BYTE_W-1:0] DAY_KEEP =
        BYTE_W'((1 << MASK_POS) | ((1 << DAY_W) - 1));

    typedef enum logic [SEL_W-1:0] {
        SEL_MIN  = 2'd0,
        SEL_HOUR = 2'd1,
        SEL_DAY  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] min_b;
        logic [BYTE_W-1:0] hour_b;
        logic [BYTE_W-1:0] day_b;
    } alarm_bytes_t;

    typedef struct packed {
        logic flag;
        logic latched;
    } flag_state_t;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output alarm_bytes_t      bytes,
    output logic              access
);
    alarm_bytes_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (sel_e'(sel))
                SEL_MIN:  regs_d.min_b  = wdata;
                SEL_HOUR: regs_d.hour_b = wdata;
                SEL_DAY:  regs_d.day_b  = wdata & DAY_KEEP;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel_e'(sel))
            SEL_MIN:  rdata = regs_q.min_b;
            SEL_HOUR: rdata = regs_q.hour_b;
            SEL_DAY:  rdata = regs_q.day_b;
            default:  rdata = '0;
        endcase
    end

    assign access = (wr || rd) && (sel_e'(sel) != SEL_NONE);
    assign bytes  = regs_q;

    p_day_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.day_b & ~DAY_KEEP) == '0)
        else $error("reserved day bits nonzero");

    p_min_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_e'(sel) == SEL_MIN) |=> regs_q.min_b == $past(wdata))
        else $error("minutes byte not stored");

    p_hour_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_e'(sel) == SEL_HOUR) |=> regs_q.hour_b == $past(wdata))
        else $error("hours byte not stored");
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
    import tod_alarm_pkg::*;
(
    input  alarm_bytes_t      bytes,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_day,
    input  logic              seq_wrap,
    output logic              hit
);
    logic min_eq, hour_eq, day_eq;
    logic mask_min, mask_hour, mask_day;

    always_comb begin
        min_eq    = bytes.min_b[FIELD_W-1:0]  == now_min[FIELD_W-1:0];
        hour_eq   = bytes.hour_b[FIELD_W-1:0] == now_hour[FIELD_W-1:0];
        day_eq    = bytes.day_b[DAY_W-1:0]    == now_day[DAY_W-1:0];
        mask_min  = bytes.min_b[MASK_POS];
        mask_hour = bytes.hour_b[MASK_POS];
        mask_day  = bytes.day_b[MASK_POS];

        if (mask_day && mask_hour && mask_min) hit = seq_wrap;
        else if (mask_day && mask_hour)        hit = min_eq;
        else if (mask_day)                     hit = min_eq && hour_eq;
        else                                   hit = min_eq && hour_eq && day_eq;
    end
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
    import tod_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_win,
    input  logic hit,
    input  logic access,
    input  logic irq_mask,
    output logic flag,
    output logic irq
);
    flag_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d = st_q;
        fire = chk_win && hit && !st_q.latched;
        if (chk_win) st_d.latched = hit;
        if (fire)        st_d.flag = 1'b1;
        else if (access) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag && !irq_mask;

    p_fresh_hit_sets_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_win && hit && !st_q.latched) |=> flag)
        else $error("fresh hit did not set flag");

    p_access_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !(chk_win && hit && !st_q.latched)) |=> !flag)
        else $error("access did not clear flag");

    p_repeat_hit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_win && st_q.latched && !access) |=> $stable(flag))
        else $error("repeated hit changed flag");

    p_idle_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_win && !access) |=> $stable(flag))
        else $error("flag moved without check or access");
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_day,
    input  logic              seq_wrap,
    input  logic              chk_win,
    input  logic              irq_mask,
    output logic              alarm_flag,
    output logic              irq_out
);
    alarm_bytes_t bytes;
    logic         access;
    logic         hit;

    alarm_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (wr_data),
        .rdata  (rd_data),
        .bytes  (bytes),
        .access (access)
    );

    alarm_compare u_cmp (
        .bytes    (bytes),
        .now_min  (now_min),
        .now_hour (now_hour),
        .now_day  (now_day),
        .seq_wrap (seq_wrap),
        .hit      (hit)
    );

    alarm_flag_ctrl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_win  (chk_win),
        .hit      (hit),
        .access   (access),
        .irq_mask (irq_mask),
        .flag     (alarm_flag),
        .irq      (irq_out)
    );

    p_masked_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq_out)
        else $error("irq active while masked");

    p_no_check_no_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_win |=> !$rose(alarm_flag))
        else $error("flag rose without check window");
endmodule

// File: tb/test_tod_alarm_match.sv
module test_tod_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd3;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] now_min = 8'h00, now_hour = 8'h00, now_day = 8'h00;
    logic       seq_wrap = 1'b0, chk_win = 1'b0, irq_mask = 1'b0;
    logic       alarm_flag, irq_out;

    int checks = 0, errors = 0;
    logic [7:0] m_min = 0, m_hour = 0, m_day = 0;
    logic       m_lat = 0, m_flag = 0;

    always #10 clk = ~clk;

    tod_alarm_match i_tod_alarm_match (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
        .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .seq_wrap(seq_wrap), .chk_win(chk_win), .irq_mask(irq_mask),
        .alarm_flag(alarm_flag), .irq_out(irq_out)
    );

    function automatic logic m_cond(logic [7:0] am, logic [7:0] ah, logic [7:0] ad,
                                    logic [7:0] cm, logic [7:0] ch, logic [7:0] cd,
                                    logic sw);
        logic mm, hm, dm;
        mm = am[6:0] == cm[6:0];
        hm = ah[6:0] == ch[6:0];
        dm = ad[2:0] == cd[2:0];
        if (ad[7] && ah[7] && am[7]) return sw;
        if (ad[7] && ah[7]) return mm;
        if (ad[7]) return mm && hm;
        return mm && hm && dm;
    endfunction

    function automatic logic [7:0] m_read(logic [1:0] s);
        case (s)
            2'd0: return m_min;
            2'd1: return m_hour;
            2'd2: return m_day;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [1:0] s, logic w, logic r, logic [7:0] d,
                        logic [7:0] cm, logic [7:0] ch, logic [7:0] cd,
                        logic sw, logic cw, logic im);
        logic ev, acc;
        reg_sel = s; reg_wr = w; reg_rd = r; wr_data = d;
        now_min = cm; now_hour = ch; now_day = cd;
        seq_wrap = sw; chk_win = cw; irq_mask = im;
        #1;
        chk({tag, " rd_data R1"}, rd_data, m_read(s));
        ev  = cw && m_cond(m_min, m_hour, m_day, cm, ch, cd, sw) && !m_lat;
        acc = (w || r) && (s != 2'd3);
        if (cw) m_lat = m_cond(m_min, m_hour, m_day, cm, ch, cd, sw);
        if (ev) m_flag = 1'b1;
        else if (acc) m_flag = 1'b0;
        if (w) begin
            case (s)
                2'd0: m_min = d;
                2'd1: m_hour = d;
                2'd2: m_day = d & 8'h87;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk({tag, " flag"}, {7'd0, alarm_flag}, {7'd0, m_flag});
        chk({tag, " irq R11"}, {7'd0, irq_out}, {7'd0, m_flag && !im});
    endtask

    task automatic wrb(string tag, logic [1:0] s, logic [7:0] d);
        step(tag, s, 1'b1, 1'b0, d, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic tick(string tag, logic [7:0] cm, logic [7:0] ch, logic [7:0] cd,
                        logic sw, logic cw);
        step(tag, 2'd3, 1'b0, 1'b0, 8'h00, cm, ch, cd, sw, cw, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 flag", {7'd0, alarm_flag}, 8'h00);
        chk("R12 irq", {7'd0, irq_out}, 8'h00);
        for (int s = 0; s < 3; s++) begin
            reg_sel = 2'(s); #1;
            chk("R12 byte", rd_data, 8'h00);
        end

        // R1 R2: storage and reserved bits
        wrb("R1 min", 2'd0, 8'h30);
        wrb("R1 hour", 2'd1, 8'h12);
        wrb("R2 day", 2'd2, 8'hFD);
        reg_sel = 2'd2; #1;
        chk("R2 day readback", rd_data, 8'h85);
        reg_sel = 2'd3; #1;
        chk("R1 unused select", rd_data, 8'h00);

        // R4: daily alarm
        tick("R13 no window", 8'h30, 8'h12, 8'h01, 1'b0, 1'b0);
        tick("R4 daily hit", 8'h30, 8'h12, 8'h01, 1'b0, 1'b1);
        chk("R4 flag set", {7'd0, alarm_flag}, 8'h01);
        tick("R8 repeat hit", 8'h30, 8'h12, 8'h01, 1'b0, 1'b1);
        step("R9 read clears", 2'd0, 1'b0, 1'b1, 8'h00, 8'h30, 8'h12, 8'h01, 1'b0, 1'b0, 1'b0);
        chk("R9 cleared", {7'd0, alarm_flag}, 8'h00);
        tick("R8 no re-set", 8'h30, 8'h12, 8'h01, 1'b0, 1'b1);
        chk("R8 still clear", {7'd0, alarm_flag}, 8'h00);
        tick("R8 miss", 8'h31, 8'h12, 8'h01, 1'b0, 1'b1);
        tick("R8 rearmed hit", 8'h30, 8'h12, 8'h04, 1'b0, 1'b1);
        chk("R8 set again", {7'd0, alarm_flag}, 8'h01);
        step("R9 unused access", 2'd3, 1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        chk("R9 unused keeps flag", {7'd0, alarm_flag}, 8'h01);
        step("R11 masked", 2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
        chk("R11 flag kept", {7'd0, alarm_flag}, 8'h01);

        // R3: full match required
        wrb("R3 day", 2'd2, 8'h03);
        tick("R3 day miss", 8'h30, 8'h12, 8'h04, 1'b0, 1'b1);
        chk("R3 miss clear", {7'd0, alarm_flag}, 8'h00);
        tick("R3 full hit", 8'h30, 8'h12, 8'h03, 1'b0, 1'b1);
        chk("R3 set", {7'd0, alarm_flag}, 8'h01);

        // R10: set wins over same-cycle clear
        wrb("R10 prep", 2'd0, 8'h45);
        tick("R10 miss", 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
        step("R10 collide", 2'd1, 1'b0, 1'b1, 8'h00, 8'h45, 8'h12, 8'h03, 1'b0, 1'b1, 1'b0);
        chk("R10 set wins", {7'd0, alarm_flag}, 8'h01);

        // R5: hourly
        wrb("R5 hour", 2'd1, 8'h92);
        wrb("R5 day", 2'd2, 8'h80);
        tick("R5 miss", 8'h44, 8'h07, 8'h06, 1'b0, 1'b1);
        tick("R5 hit", 8'h45, 8'h07, 8'h06, 1'b0, 1'b1);
        chk("R5 set", {7'd0, alarm_flag}, 8'h01);

        // R7: minutes mask alone needs full match
        wrb("R7 min", 2'd0, 8'hB0);
        wrb("R7 hour", 2'd1, 8'h12);
        wrb("R7 day", 2'd2, 8'h03);
        tick("R7 partial", 8'h30, 8'h12, 8'h05, 1'b0, 1'b1);
        chk("R7 no set", {7'd0, alarm_flag}, 8'h00);
        tick("R7 full", 8'h30, 8'h12, 8'h03, 1'b0, 1'b1);
        chk("R7 set", {7'd0, alarm_flag}, 8'h01);

        // R6: every minute on rollover
        wrb("R6 min", 2'd0, 8'h80);
        wrb("R6 hour", 2'd1, 8'h80);
        wrb("R6 day", 2'd2, 8'h80);
        tick("R6 no wrap", 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
        chk("R6 no set", {7'd0, alarm_flag}, 8'h00);
        tick("R6 wrap", 8'h17, 8'h23, 8'h02, 1'b1, 1'b1);
        chk("R6 set", {7'd0, alarm_flag}, 8'h01);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] s; logic w, r, sw, cw, im;
            logic [7:0] d, cm, ch, cd;
            s  = 2'($urandom % 4);
            w  = ($urandom % 12) == 0;
            r  = ($urandom % 12) == 0;
            d  = 8'($urandom);
            if (($urandom % 2) == 0) d[7] = 1'b1;
            cm = ($urandom % 2) ? m_min  : 8'($urandom % 8'h60);
            ch = ($urandom % 2) ? m_hour : 8'($urandom % 8'h24);
            cd = ($urandom % 2) ? m_day  : 8'($urandom % 8);
            sw = ($urandom % 4) == 0;
            cw = ($urandom % 3) == 0;
            im = ($urandom % 5) == 0;
            step("R8 random", s, w, r, d, cm, ch, cd, sw, cw, im);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule